// File: doc/BRIEF.md
# Signed Register-Mapped Divider

This block is a divider peripheral hung on a small synchronous register bus. Software stores a 32-bit signed dividend, then stores a 16-bit signed divisor; storing the divisor launches the division. An iterative engine produces one quotient bit per clock. The block corrects the signs of the magnitudes afterwards and loads a 32-bit quotient and a 16-bit signed remainder into result registers. The remainder is widened to 32 bits by copying its sign bit upward. A divide-by-zero flag is refreshed by every divisor store.

The bus uses a valid/ready handshake. An access is taken on a rising clock edge at which `req_valid` and `req_ready` are both high. The requester must hold `req_write`, `req_addr` and `req_wdata` steady while `req_ready` is low. `req_ready` drops only for a read of a result register while a division is in flight, which applies back-pressure until the result lands. Every other access is taken in the cycle it is offered. Read data on `rsp_rdata` is valid in the cycle of the read handshake. Unmapped addresses read zero and ignore writes.

Top module: `sdiv_regbus`

## Requirements
- R1: Byte addresses are: 0x00 dividend (32 bits, read back as written), 0x04 divisor, 0x08 quotient, 0x0C remainder and 0x10 status. Only bits [15:0] of a divisor store are kept, and the divisor reads back zero-extended.
- R2: A divisor store starts a division on the dividend held at that moment. A dividend store made while the division runs changes the dividend register but not the result.
- R3: For a nonzero divisor, the quotient equals the signed dividend divided by the signed divisor, truncated toward zero, taken as the low 32 bits. This means -2^31 / -1 reads 0x80000000.
- R4: For a nonzero divisor, the remainder is dividend minus quotient times divisor. It has the dividend's sign and a magnitude below that of the divisor. It sits in bits [15:0], and bits [31:16] all copy bit 15.
- R5: A zero divisor runs no iteration and cancels any division in flight. The quotient becomes 0xFFFFFFFF, and the remainder becomes the dividend's bits [15:0] sign-extended. Both load on the edge that takes the store, so a following read does not stall.
- R6: Status bit 1 is set by a store of a zero divisor and cleared by a store of a nonzero one. All other status bits read 0, and stores to the status address change nothing.
- R7: While a division is running, a read of the quotient or remainder address holds `req_ready` low until the result has loaded. Reads of any other address, and all stores, are taken at once.
- R8: The results load on the 33rd rising edge after the edge that takes a nonzero divisor store.
- R9: The quotient and remainder can be stored directly. A direct store taken on or before the result-load edge is replaced by the result, and one taken after it persists.
- R10: After reset, every register reads zero.
- R11: A divisor store made during a running division abandons it and restarts with the new operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access offered |
| req_ready | output | 1 | Access can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = read |
| req_addr | input | 5 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_rdata | output | 32 | Read data, valid in the read handshake cycle |

## Verification
Two functions can fall in the same cycle: loading the result and a direct software store to a result register. The bench counts edges from the divisor handshake and places a quotient store exactly on the 33rd edge, where the result must win. It then places one on the 34th edge, where the stored word must survive. The bench also aims a read at the cycle in which the result is still pending and expects exactly one stall cycle. A zero divisor store that lands while a division runs is judged by checking that the sentinel results stay in place well past the edge where the abandoned result would have loaded.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  localparam int DATA_W = 32;
  localparam int DVS_W  = 16;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_DVD  = 5'h00;
  localparam logic [ADDR_W-1:0] OFF_DVS  = 5'h04;
  localparam logic [ADDR_W-1:0] OFF_QUO  = 5'h08;
  localparam logic [ADDR_W-1:0] OFF_REM  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFF_STAT = 5'h10;
endpackage

// File: rtl/sdiv_engine.sv
module sdiv_engine #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o,
  output logic [DEN_W-2:0] rem_o
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-2:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] trial, rem_nx;
  logic             fits;

  // shift the next dividend bit into the partial remainder and try a subtract
  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    fits   = (trial >= den_q);
    rem_nx = fits ? (trial - den_q) : trial;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        busy_q <= 1'b0;
      end else if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
      end else if (busy_q) begin
        quo_q <= {quo_q[NUM_W-2:0], fits};
        rem_q <= rem_nx[DEN_W-2:0];
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !abort_i) |=> busy_o);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  // R4
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (!rem_nx[DEN_W-1] && ({1'b0, rem_q} < den_q)));
  // R5
  no_zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> (den_i != '0));
endmodule

// File: rtl/sdiv_signfix.sv
module sdiv_signfix #(
  parameter int NUM_W = 32,
  parameter int DVS_W = 16
) (
  input  logic [NUM_W-1:0] quo_mag,
  input  logic [DVS_W-1:0] rem_mag,
  input  logic             neg_quo,
  input  logic             neg_rem,
  output logic [NUM_W-1:0] quo_o,
  output logic [NUM_W-1:0] rem_o
);
  logic [DVS_W-1:0] rem_s;

  always_comb begin
    quo_o = neg_quo ? (-quo_mag) : quo_mag;
    rem_s = neg_rem ? (-rem_mag) : rem_mag;
    rem_o = {{(NUM_W-DVS_W){rem_s[DVS_W-1]}}, rem_s};
  end
endmodule

// File: rtl/sdiv_regbus.sv
module sdiv_regbus
  import sdiv_pkg::*;
#(
  parameter int DW = sdiv_pkg::DATA_W,
  parameter int VW = sdiv_pkg::DVS_W,
  parameter int AW = sdiv_pkg::ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata
);
  localparam int DEN_W = VW + 1;

  logic [DW-1:0]    dvd_q, quo_q, rem_q;
  logic [VW-1:0]    dvs_q;
  logic             dz_q, negq_q, negr_q;
  logic             eng_busy, eng_done, busy;
  logic [DW-1:0]    eng_quo, fix_quo, fix_rem, num_mag;
  logic [VW-1:0]    eng_rem;
  logic [DEN_W-1:0] den_sx, den_mag;
  logic             hit_dvd, hit_dvs, hit_quo, hit_rem, hit_stat;
  logic             wr, dvs_wr, dvs_zero, start;

  always_comb begin
    hit_dvd  = (req_addr == OFF_DVD);
    hit_dvs  = (req_addr == OFF_DVS);
    hit_quo  = (req_addr == OFF_QUO);
    hit_rem  = (req_addr == OFF_REM);
    hit_stat = (req_addr == OFF_STAT);
    busy      = eng_busy | eng_done;
    req_ready = !(!req_write && (hit_quo || hit_rem) && busy);
    wr        = req_valid && req_ready && req_write;
    dvs_wr    = wr && hit_dvs;
    dvs_zero  = (req_wdata[VW-1:0] == '0);
    start     = dvs_wr && !dvs_zero;
    num_mag   = dvd_q[DW-1] ? (-dvd_q) : dvd_q;
    den_sx    = {req_wdata[VW-1], req_wdata[VW-1:0]};
    den_mag   = den_sx[DEN_W-1] ? (-den_sx) : den_sx;
  end

  sdiv_engine #(.NUM_W(DW), .DEN_W(DEN_W)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .abort_i (dvs_wr && dvs_zero),
    .num_i   (num_mag),
    .den_i   (den_mag),
    .busy_o  (eng_busy),
    .done_o  (eng_done),
    .quo_o   (eng_quo),
    .rem_o   (eng_rem)
  );

  sdiv_signfix #(.NUM_W(DW), .DVS_W(VW)) u_signfix (
    .quo_mag (eng_quo),
    .rem_mag (eng_rem),
    .neg_quo (negq_q),
    .neg_rem (negr_q),
    .quo_o   (fix_quo),
    .rem_o   (fix_rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q  <= '0;
      dvs_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      dz_q   <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
    end else begin
      if (wr && hit_dvd) dvd_q <= req_wdata;
      if (dvs_wr) begin
        dvs_q <= req_wdata[VW-1:0];
        dz_q  <= dvs_zero;
      end
      if (start) begin
        negq_q <= dvd_q[DW-1] ^ req_wdata[VW-1];
        negr_q <= dvd_q[DW-1];
      end
      // zero store outranks a finishing result; the result outranks direct stores
      if (dvs_wr && dvs_zero) begin
        quo_q <= '1;
        rem_q <= {{(DW-VW){dvd_q[VW-1]}}, dvd_q[VW-1:0]};
      end else if (eng_done) begin
        quo_q <= fix_quo;
        rem_q <= fix_rem;
      end else begin
        if (wr && hit_quo) quo_q <= req_wdata;
        if (wr && hit_rem) rem_q <= req_wdata;
      end
    end
  end

  always_comb begin
    rsp_rdata = '0;
    if (hit_dvd)  rsp_rdata = dvd_q;
    if (hit_dvs)  rsp_rdata = {{(DW-VW){1'b0}}, dvs_q};
    if (hit_quo)  rsp_rdata = quo_q;
    if (hit_rem)  rsp_rdata = rem_q;
    if (hit_stat) rsp_rdata = {{(DW-2){1'b0}}, dz_q, 1'b0};
  end

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dvs_wr |=> (dz_q == $past(dvs_zero)));
  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_write && (hit_quo || hit_rem)) |-> (!eng_busy && !eng_done));
  // R5
  zero_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dvs_wr && dvs_zero) |=> (!eng_busy && !eng_done && (quo_q == '1)));
  // R9
  result_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !dvs_wr) |=> (quo_q == $past(fix_quo) && rem_q == $past(fix_rem)));
endmodule

// File: tb/sdiv_regbus_tb.sv
`timescale 1ns/1ps
module sdiv_regbus_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rsp_rdata;

  int n_chk = 0;
  int n_bad = 0;

  localparam logic [4:0] A_DVD = 5'h00, A_DVS = 5'h04, A_QUO = 5'h08,
                         A_REM = 5'h0C, A_STAT = 5'h10;

  always #10 clk = ~clk;

  sdiv_regbus u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(posedge clk);
  endtask

  task automatic bus_idle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output int stalls);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; stalls = 0;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
      stalls++;
    end
    d = rsp_rdata;
    @(posedge clk);
  endtask

  function automatic logic [31:0] exp_quo(input int a, input int b);
    longint q;
    if (b == 0) return 32'hFFFF_FFFF;
    q = longint'(a) / longint'(b);
    return q[31:0];
  endfunction

  function automatic logic [31:0] exp_rem(input int a, input int b);
    longint r;
    if (b == 0) return {{16{a[15]}}, a[15:0]};
    r = longint'(a) % longint'(b);
    return r[31:0];
  endfunction

  function automatic logic [31:0] dvs_word(input int b);
    return {16'hA5A5, b[15:0]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    logic [31:0] d;
    int st;
    int dvds [12] = '{0, 1, -1, 7, -7, 100, -100, 32'h7FFF_FFFF, 32'h8000_0000,
                      12345678, -12345678, 65536};
    int dvss [12] = '{1, -1, 2, -2, 3, -3, 7, -7, 32767, -32768, 0, 255};

    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    bus_read(A_DVD, d, st);  chk("R10 dividend", d, 32'h0);
    bus_read(A_DVS, d, st);  chk("R10 divisor", d, 32'h0);
    bus_read(A_QUO, d, st);  chk("R10 quotient", d, 32'h0);
    bus_read(A_REM, d, st);  chk("R10 remainder", d, 32'h0);
    bus_read(A_STAT, d, st); chk("R10 status", d, 32'h0);

    // R1 map and divisor width
    bus_write(A_DVD, 32'hDEAD_BEEF);
    bus_read(A_DVD, d, st); chk("R1 dividend readback", d, 32'hDEAD_BEEF);
    bus_write(A_DVS, 32'h1234_0005);
    bus_read(A_DVS, d, st); chk("R1 divisor low bits", d, 32'h0000_0005);
    bus_read(A_QUO, d, st); chk("R1 quotient after upper junk", d, exp_quo(int'(32'hDEAD_BEEF), 5));

    // R3 R4 R5 R6 R7 sweep
    foreach (dvds[i]) begin
      foreach (dvss[j]) begin
        bus_write(A_DVD, dvds[i]);
        bus_write(A_DVS, dvs_word(dvss[j]));
        bus_read(A_QUO, d, st);
        chk(dvss[j] == 0 ? "R5 quotient" : "R3 quotient", d, exp_quo(dvds[i], dvss[j]));
        if (dvss[j] == 0) chk("R5 no stall", 32'(st), 32'd0);
        else              chk("R7 read stalled", 32'(st > 0), 32'd1);
        bus_read(A_REM, d, st);
        chk(dvss[j] == 0 ? "R5 remainder" : "R4 remainder", d, exp_rem(dvds[i], dvss[j]));
        bus_read(A_STAT, d, st);
        chk("R6 status flag", d, dvss[j] == 0 ? 32'h2 : 32'h0);
      end
    end

    // R6 status ignores stores
    bus_write(A_DVS, 32'h0);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, d, st); chk("R6 status store ignored set", d, 32'h2);
    bus_write(A_DVS, 32'h3);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, d, st); chk("R6 status store ignored clear", d, 32'h0);

    // R7 other addresses taken at once while busy
    bus_write(A_DVD, 1000);
    bus_write(A_DVS, 7);
    bus_read(A_STAT, d, st); chk("R7 status read no stall", 32'(st), 32'd0);
    bus_read(A_DVS, d, st);  chk("R7 divisor read no stall", 32'(st), 32'd0);

    // R2 dividend store during calculation
    bus_write(A_DVD, -5000);
    bus_write(A_DVS, dvs_word(13));
    bus_write(A_DVD, 77);
    bus_read(A_QUO, d, st); chk("R2 quotient uses held dividend", d, exp_quo(-5000, 13));
    bus_read(A_REM, d, st); chk("R2 remainder uses held dividend", d, exp_rem(-5000, 13));
    bus_read(A_DVD, d, st); chk("R2 dividend register updated", d, 32'd77);

    // R8 load edge: read offered before edge 33 stalls once, before edge 34 not at all
    bus_write(A_DVD, 999);
    bus_write(A_DVS, 4);
    repeat (32) bus_idle();
    bus_read(A_QUO, d, st);
    chk("R8 one stall at edge 33", 32'(st), 32'd1);
    chk("R8 quotient", d, 32'd249);
    bus_write(A_DVS, 4);
    repeat (33) bus_idle();
    bus_read(A_QUO, d, st);
    chk("R8 no stall after load", 32'(st), 32'd0);

    // R9 direct store on the load edge loses, one edge later wins
    bus_write(A_DVD, -123456);
    bus_write(A_DVS, dvs_word(-321));
    repeat (32) bus_idle();
    bus_write(A_QUO, 32'h5555_AAAA);
    bus_read(A_QUO, d, st); chk("R9 result wins on load edge", d, exp_quo(-123456, -321));
    bus_write(A_DVS, dvs_word(-321));
    repeat (33) bus_idle();
    bus_write(A_QUO, 32'h5555_AAAA);
    bus_read(A_QUO, d, st); chk("R9 later store persists", d, 32'h5555_AAAA);
    bus_write(A_REM, 32'h0BAD_F00D);
    bus_read(A_REM, d, st); chk("R9 remainder store idle", d, 32'h0BAD_F00D);

    // R11 restart during calculation
    bus_write(A_DVD, 50000);
    bus_write(A_DVS, 3);
    repeat (5) bus_idle();
    bus_write(A_DVD, -90001);
    bus_write(A_DVS, dvs_word(-17));
    bus_read(A_QUO, d, st); chk("R11 restart quotient", d, exp_quo(-90001, -17));
    bus_read(A_REM, d, st); chk("R11 restart remainder", d, exp_rem(-90001, -17));

    // R5 zero divisor cancels a running division
    bus_write(A_DVD, 32'h1234_8001);
    bus_write(A_DVS, 9);
    repeat (4) bus_idle();
    bus_write(A_DVS, 32'hFFFF_0000);
    repeat (40) bus_idle();
    bus_read(A_QUO, d, st); chk("R5 abort quotient", d, 32'hFFFF_FFFF);
    bus_read(A_REM, d, st); chk("R5 abort remainder", d, 32'hFFFF_8001);

    report();
  end
endmodule